// File: doc/BRIEF.md
# Key-Guarded Command Sequence Table

This block stores the serial-flash command sequences used by a flash controller's sequencer. It has 64 words of 32 bits. Software reaches them through a memory-mapped write port and a combinational read port. The sequencer reads the table through its own combinational port. That port takes a sequence number and an instruction slot, where each sequence spans four words and each word holds two 16-bit instruction slots.

The table can be frozen. A change to the lock state takes two writes in a row. The first puts the magic value 0x5AF05AF0 into the key register at byte offset 0x300. The next write goes to the lock-control register at 0x304: value 0x1 locks the table and value 0x2 unlocks it. Any other write in between, or a wrong key value, cancels the key. While the table is locked, writes to table words are dropped. Reads stay allowed at all times.

The write port uses valid/ready. `cfg_wready` is held high, so the block never applies back-pressure: every cycle with `cfg_wvalid` high is one accepted write, taken at the rising clock edge. Software normally unlocks the table, writes zero to all words, programs its sequences and then locks the table again.

Top module: `seqtab_keyed`

## Requirements
- R1: After reset the table is unlocked. `tab_locked` is 0, every table word reads 0, and reading offset 0x304 returns 0.
- R2: While unlocked, an accepted write to byte offset 0x310 + 4*i (i in 0..63) stores the data in word i. The new value is visible on `cfg_rdata` at the same offset after that clock edge.
- R3: `seq_word` returns table word 4*`seq_id` + `seq_slot`/2 (integer division), combinationally.
- R4: A write of 0x5AF05AF0 to offset 0x300, followed by the very next write of 0x1 to offset 0x304, locks the table. `tab_locked` becomes 1 and bit 0 of a read at 0x304 becomes 1. A repeated correct key keeps the key pending.
- R5: While locked, writes to table words do not change any stored word.
- R6: The correct key followed by a write of 0x2 to offset 0x304 unlocks the table, and table writes take effect again.
- R7: A write to offset 0x304 that does not directly follow a correct key write leaves the lock state unchanged.
- R8: A key write with any value other than 0x5AF05AF0 does not allow a following lock-control write to take effect.
- R9: Any other accepted write between the key write and the lock-control write cancels the key. This includes table writes, writes to unmapped offsets, and writes dropped while locked.
- R10: After a correct key, a lock-control write of any value other than 0x1 or 0x2 leaves the lock state unchanged and uses up the key.
- R11: While locked, table words stay readable on both `cfg_rdata` and `seq_word`.
- R12: `cfg_wready` is always 1, so every cycle with `cfg_wvalid` high counts as exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wvalid | input | 1 | Write request valid |
| cfg_wready | output | 1 | Write request accepted (always 1) |
| cfg_waddr | input | 12 | Write byte offset |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 12 | Read byte offset |
| cfg_rdata | output | 32 | Read data (table word, lock status at 0x304, else 0) |
| seq_id | input | 4 | Sequence number for the sequencer port |
| seq_slot | input | 3 | Instruction slot within the sequence |
| seq_word | output | 32 | Table word holding the selected slot |
| tab_locked | output | 1 | Current lock state |

## Verification
The handshake is driven with these write patterns:
- a correct key followed directly by each command;
- a command with no key before it;
- a key that is one bit off;
- a correct key separated from the command by an unmapped write or by a dropped table write;
- a key followed by an unknown command value and then a bare command.

Together these separate "key pending" from "key seen at some point". The table itself is tried with writes while unlocked and while locked, at the first, last and a middle word. That shows whether the index decode, the lock gate and the sequencer index arithmetic each hold at the edges of the array.

// File: rtl/seqtab_pkg.sv
package seqtab_pkg;

  localparam logic [31:0] KEY_MAGIC = 32'h5AF0_5AF0;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_LOCK   = 2'd1,
    CMD_UNLOCK = 2'd2
  } lock_cmd_e;

  function automatic lock_cmd_e decode_cmd(input logic [31:0] d);
    if (d == 32'h1) return CMD_LOCK;
    if (d == 32'h2) return CMD_UNLOCK;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/seqtab_decode.sv
module seqtab_decode #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 64,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h300,
  parameter logic [ADDR_W-1:0] TAB_BASE = 12'h310
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_key,
  output logic              is_ctrl,
  output logic              is_tab,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = KEY_ADDR + ADDR_W'(4);
  localparam int TAB_END = int'(TAB_BASE) + DEPTH * 4;

  always_comb begin
    is_key  = (addr == KEY_ADDR);
    is_ctrl = (addr == CTRL_ADDR);
    is_tab  = (addr >= TAB_BASE) && (int'(addr) < TAB_END) && (addr[1:0] == 2'b00);
    idx     = IDX_W'((addr - TAB_BASE) >> 2);
  end
endmodule

// File: rtl/seqtab_guard.sv
module seqtab_guard
  import seqtab_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              is_key,
  input  logic              is_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  logic armed_q;
  logic locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
    end else if (wr_valid) begin
      armed_q <= is_key && (wdata == DATA_W'(KEY_MAGIC));
      if (is_ctrl && armed_q) begin
        case (decode_cmd(32'(wdata)))
          CMD_LOCK:   locked_q <= 1'b1;
          CMD_UNLOCK: locked_q <= 1'b0;
          default:    locked_q <= locked_q;
        endcase
      end
    end
  end

  assign locked = locked_q;

  // R7
  ctrl_without_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && is_ctrl && !armed_q) |=> $stable(locked_q));

  // R9
  key_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !is_key) |=> !armed_q);

  // R4
  lock_change_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(locked_q) |-> $past(wr_valid && is_ctrl && armed_q));

  // R10
  unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && is_ctrl && armed_q && wdata != DATA_W'(1) && wdata != DATA_W'(2))
      |=> $stable(locked_q));
endmodule

// File: rtl/seqtab_array.sv
module seqtab_array #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              locked,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (we && !locked && widx == IDX_W'(g))
        mem_q[g] <= wdata;
    end
  end

  assign rdata_a = mem_q[ridx_a];
  assign rdata_b = mem_q[ridx_b];

  // R5
  frozen_contents_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(mem_q));
endmodule

// File: rtl/seqtab_keyed.sv
module seqtab_keyed #(
  parameter int ADDR_W         = 12,
  parameter int DATA_W         = 32,
  parameter int DEPTH          = 64,
  parameter int WORDS_PER_SEQ  = 4,
  parameter int SLOTS_PER_WORD = 2,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h300,
  parameter logic [ADDR_W-1:0] TAB_BASE = 12'h310,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int SEQ_W  = $clog2(DEPTH / WORDS_PER_SEQ),
  localparam int SLOT_W = $clog2(WORDS_PER_SEQ * SLOTS_PER_WORD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wvalid,
  output logic              cfg_wready,
  input  logic [ADDR_W-1:0] cfg_waddr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cfg_raddr,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [SEQ_W-1:0]  seq_id,
  input  logic [SLOT_W-1:0] seq_slot,
  output logic [DATA_W-1:0] seq_word,
  output logic              tab_locked
);
  logic             w_key, w_ctrl, w_tab;
  logic [IDX_W-1:0] w_idx;
  logic             r_key, r_ctrl, r_tab;
  logic [IDX_W-1:0] r_idx;
  logic [IDX_W-1:0] s_idx;
  logic [DATA_W-1:0] tab_rdata;
  logic             locked;

  seqtab_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                  .KEY_ADDR(KEY_ADDR), .TAB_BASE(TAB_BASE)) u_wdec (
    .addr(cfg_waddr), .is_key(w_key), .is_ctrl(w_ctrl), .is_tab(w_tab), .idx(w_idx));

  seqtab_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .IDX_W(IDX_W),
                  .KEY_ADDR(KEY_ADDR), .TAB_BASE(TAB_BASE)) u_rdec (
    .addr(cfg_raddr), .is_key(r_key), .is_ctrl(r_ctrl), .is_tab(r_tab), .idx(r_idx));

  seqtab_guard #(.DATA_W(DATA_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .wr_valid(cfg_wvalid), .is_key(w_key),
    .is_ctrl(w_ctrl), .wdata(cfg_wdata), .locked(locked));

  assign s_idx = IDX_W'(seq_id) * IDX_W'(WORDS_PER_SEQ)
               + IDX_W'(seq_slot / SLOT_W'(SLOTS_PER_WORD));

  seqtab_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(cfg_wvalid && w_tab), .locked(locked),
    .widx(w_idx), .wdata(cfg_wdata), .ridx_a(r_idx), .rdata_a(tab_rdata),
    .ridx_b(s_idx), .rdata_b(seq_word));

  always_comb begin
    if (r_tab)       cfg_rdata = tab_rdata;
    else if (r_ctrl) cfg_rdata = DATA_W'(locked);
    else if (r_key)  cfg_rdata = '0;
    else             cfg_rdata = '0;
  end

  assign cfg_wready = 1'b1;
  assign tab_locked = locked;
endmodule

// File: tb/seqtab_keyed_test.sv
module seqtab_keyed_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h5AF0_5AF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wvalid = 1'b0;
  logic        cfg_wready;
  logic [11:0] cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [11:0] cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic [3:0]  seq_id = '0;
  logic [2:0]  seq_slot = '0;
  logic [31:0] seq_word;
  logic        tab_locked;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seqtab_keyed uut (
    .clk(clk), .rst_n(rst_n), .cfg_wvalid(cfg_wvalid), .cfg_wready(cfg_wready),
    .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr),
    .cfg_rdata(cfg_rdata), .seq_id(seq_id), .seq_slot(seq_slot),
    .seq_word(seq_word), .tab_locked(tab_locked));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wvalid = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wvalid = 1'b0;
  endtask

  function automatic logic [11:0] taddr(input int i);
    return 12'(12'h310 + 4 * i);
  endfunction

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    cfg_raddr = a;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic seq_check(input string req, input int id, input int slot, input logic [31:0] exp);
    seq_id = 4'(id); seq_slot = 3'(slot);
    #1;
    check(req, seq_word, exp);
  endtask

  task automatic t_reset();
    check("R1 locked", 32'(tab_locked), 0);
    rd_check("R1 word0", taddr(0), 0);
    rd_check("R1 word63", taddr(63), 0);
    rd_check("R1 status", 12'h304, 0);
    check("R12 ready", 32'(cfg_wready), 1);
  endtask

  task automatic t_write_read();
    wr(taddr(0), 32'h1111_0001);
    wr(taddr(63), 32'hA5A5_5A5A);
    wr(taddr(5), 32'h0BAD_CAFE);
    rd_check("R2 word0", taddr(0), 32'h1111_0001);
    rd_check("R2 word63", taddr(63), 32'hA5A5_5A5A);
    rd_check("R2 word5", taddr(5), 32'h0BAD_CAFE);
    rd_check("R2 word6 untouched", taddr(6), 0);
  endtask

  task automatic t_seq_port();
    seq_check("R3 seq1 slot3", 1, 3, 32'h0BAD_CAFE);
    seq_check("R3 seq1 slot2", 1, 2, 32'h0BAD_CAFE);
    seq_check("R3 seq15 slot7", 15, 7, 32'hA5A5_5A5A);
    seq_check("R3 seq0 slot1", 0, 1, 32'h1111_0001);
    seq_check("R3 seq1 slot4", 1, 4, 0);
  endtask

  task automatic t_lock();
    wr(12'h300, KEY);
    wr(12'h300, KEY);
    wr(12'h304, 32'h1);
    check("R4 locked", 32'(tab_locked), 1);
    rd_check("R4 status", 12'h304, 1);
  endtask

  task automatic t_locked_write();
    wr(taddr(5), 32'hDEAD_BEEF);
    wr(taddr(0), 32'hFFFF_FFFF);
    rd_check("R5 word5 held", taddr(5), 32'h0BAD_CAFE);
    rd_check("R5 word0 held", taddr(0), 32'h1111_0001);
    seq_check("R11 seq port while locked", 1, 2, 32'h0BAD_CAFE);
    rd_check("R11 word63 readable", taddr(63), 32'hA5A5_5A5A);
  endtask

  task automatic t_no_key();
    wr(12'h304, 32'h2);
    check("R7 stays locked", 32'(tab_locked), 1);
  endtask

  task automatic t_bad_key();
    wr(12'h300, KEY ^ 32'h1);
    wr(12'h304, 32'h2);
    check("R8 stays locked", 32'(tab_locked), 1);
  endtask

  task automatic t_intervene();
    wr(12'h300, KEY);
    wr(12'h000, 32'h0);
    wr(12'h304, 32'h2);
    check("R9 unmapped write cancels", 32'(tab_locked), 1);
    wr(12'h300, KEY);
    wr(taddr(1), 32'h1234_5678);
    wr(12'h304, 32'h2);
    check("R9 dropped table write cancels", 32'(tab_locked), 1);
  endtask

  task automatic t_bad_cmd();
    wr(12'h300, KEY);
    wr(12'h304, 32'h3);
    check("R10 unknown cmd", 32'(tab_locked), 1);
    wr(12'h304, 32'h2);
    check("R10 key consumed", 32'(tab_locked), 1);
  endtask

  task automatic t_unlock();
    wr(12'h300, KEY);
    wr(12'h304, 32'h2);
    check("R6 unlocked", 32'(tab_locked), 0);
    rd_check("R6 status", 12'h304, 0);
    wr(taddr(5), 32'hC0DE_0005);
    rd_check("R6 write after unlock", taddr(5), 32'hC0DE_0005);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_seq_port();
    t_lock();
    t_locked_write();
    t_no_key();
    t_bad_key();
    t_intervene();
    t_bad_cmd();
    t_unlock();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule